// File: doc/BRIEF.md
# Trigger Busy Generator with Burst Interlock

This block drives the busy line that tells the trigger system to stop sending triggers. Busy is the OR of five causes. Each cause also appears as its own bit in a 16-bit status word. The causes are:

- the timing receiver not being ready;
- the event-buffer occupancy reaching a programmable limit;
- a hold-off window that opens after every L0 trigger;
- the trigger receiver being busy with a sequence;
- a burst limiter that has tripped.

The burst limiter is a leaky bucket. Every L0 trigger adds one token to the bucket. One token drains away each time a programmable leak interval elapses. The limiter trips while the bucket level is at or above the programmed burst size.

Both the hold-off and the leak interval count in 10 us ticks. A prescaler divides the system clock to make that one shared tick, and the tick comes every `TICK_DIV` clocks (400 at 40 MHz). A 32-bit counter adds up the clock cycles during which busy is high. Four configuration fields are loaded through a simple write strobe: the hold-off time, the buffer limit, the burst size and the leak interval.

Top module: `busy_gen`

## Requirements
- R1: While reset is asserted and just after its release, `busy_cycles` is 0 and the configuration is at its reset values: hold-off time 0x000A, and buffer limit, burst size and leak interval all 0. With `rx_ready`=1 and no other cause active, `busy` is 0.
- R2: A tick occurs on every `TICK_DIV`-th clock. An L0 trigger loads a remaining-time count with the hold-off time. Status bit 13 is 1 from the next cycle while that count is non-zero. The count drops by one on each tick and is reloaded by each new L0 trigger. A hold-off time of 0 produces no hold-off.
- R3: Status bit 15 equals the inverse of `rx_ready`.
- R4: Status bit 14 is 1 when the buffer limit is non-zero and `buf_count` is greater than or equal to it. Busy therefore stays high past the end of a hold-off while the buffer is full. A limit of 0 disables this cause.
- R5: Status bit 12 equals `seq_busy`.
- R6: Each L0 trigger raises the bucket level by one, saturating at 2^`BURST_W`-1 (63). Status bit 11 is 1 while the burst size is non-zero and the level is at or above it. A burst size of 0 disables the interlock and empties the bucket.
- R7: With a non-zero leak interval N, one token leaves the bucket every N ticks. The level never goes below 0. A trigger and a leak in the same cycle leave a non-empty level unchanged. An interval of 0 stops leakage.
- R8: `busy` is the OR of status bits 15:11. Status bits 10:8 are 0, bits 7:4 show `buf_count`, and bits 3:0 show the buffer limit.
- R9: `busy_cycles` increases by one after every clock edge at which `busy` was 1, and holds otherwise, wrapping at 2^32.
- R10: A cycle with `cfg_wr`=1 writes `cfg_wdata` at the next edge into one field, chosen by `cfg_addr`:
  - 0: hold-off time (16 bits);
  - 1: buffer limit (bits 3:0);
  - 2: burst size (bits 5:0);
  - 3: leak interval (16 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Field select: 0 hold-off, 1 limit, 2 burst size, 3 leak interval |
| cfg_wdata | input | 16 | Configuration write data |
| rx_ready | input | 1 | Timing receiver ready |
| buf_count | input | 4 | Current event-buffer occupancy |
| l0_trig | input | 1 | L0 trigger pulse, one cycle per trigger |
| seq_busy | input | 1 | Trigger receiver busy with a sequence |
| busy | output | 1 | Busy toward the trigger system |
| status | output | 16 | Per-cause status word, current count and limit |
| busy_cycles | output | 32 | Number of clock cycles with busy asserted |

## Verification
The assertions assume that `l0_trig` is a synchronous pulse and that `buf_count`, `rx_ready` and `seq_busy` change only between clock edges. They make no assumption about trigger spacing, so back-to-back triggers, triggers on a tick cycle and triggers coinciding with a leak are all legal. The stimulus drives every input at the falling edge, so it always stays within these assumptions. Directed phases hit the saturation, empty-bucket and zero-setting cases. A long random phase then mixes triggers, configuration writes and cause changes, with small field values so that hold-off expiry and leaks happen often.

// File: rtl/busy_gen_pkg.sv
package busy_gen_pkg;
    localparam int CNT_W = 4;
    localparam int STAT_W = 16;
    localparam int ST_RX    = 15;
    localparam int ST_BUF   = 14;
    localparam int ST_HOLD  = 13;
    localparam int ST_SEQ   = 12;
    localparam int ST_BURST = 11;

    typedef enum logic [1:0] {
        CFG_HOLD  = 2'd0,
        CFG_LIMIT = 2'd1,
        CFG_BURST = 2'd2,
        CFG_LEAK  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/busy_tick.sv
module busy_tick #(
    parameter int DIV = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == LAST);
        if (tick) s_d.cnt = '0;
        else      s_d.cnt = s_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (DIV > 1) begin : g_gap
            // consecutive ticks are DIV cycles apart (R2)
            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/busy_holdoff.sv
module busy_holdoff #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          l0,
    input  logic [TW-1:0] hold_time,
    output logic          active
);
    typedef struct packed {
        logic [TW-1:0] rem;
    } hold_st_t;

    hold_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (l0)                          s_d.rem = hold_time;
        else if (tick && s_q.rem != '0)  s_d.rem = s_q.rem - TW'(1);
        active = (s_q.rem != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_hold_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (l0 && hold_time != '0) |=> active);
    assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l0 && !tick) |=> $stable(s_q.rem));
endmodule

// File: rtl/busy_bucket.sv
module busy_bucket #(
    parameter int BW = 6,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          trig,
    input  logic [BW-1:0] size,
    input  logic [TW-1:0] leak_time,
    output logic          burst
);
    localparam logic [BW-1:0] LVL_MAX = '1;

    typedef struct packed {
        logic [BW-1:0] level;
        logic [TW-1:0] lcnt;
    } bkt_st_t;

    bkt_st_t s_d, s_q;
    logic leak;
    logic down;

    always_comb begin
        s_d  = s_q;
        leak = 1'b0;
        if (leak_time == '0) begin
            s_d.lcnt = '0;
        end else if (tick) begin
            if (({1'b0, s_q.lcnt} + (TW+1)'(1)) >= {1'b0, leak_time}) begin
                leak     = 1'b1;
                s_d.lcnt = '0;
            end else begin
                s_d.lcnt = s_q.lcnt + TW'(1);
            end
        end

        down = leak && (s_q.level != '0);
        if (size == '0)                                 s_d.level = '0;
        else if (trig && !down && s_q.level != LVL_MAX) s_d.level = s_q.level + BW'(1);
        else if (down && !trig)                         s_d.level = s_q.level - BW'(1);

        burst = (size != '0) && (s_q.level >= size);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_bucket_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size == '0) |=> (s_q.level == '0));
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.level == LVL_MAX && size != '0 && !leak) |=> (s_q.level == LVL_MAX));
    assert_leak_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && leak_time == '0) |=> (s_q.level == $past(s_q.level) || s_q.level == '0));
endmodule

// File: rtl/busy_gen.sv
module busy_gen
    import busy_gen_pkg::*;
#(
    parameter int          TICK_DIV = 400,
    parameter int          TIME_W   = 16,
    parameter int          BURST_W  = 6,
    parameter int          BCNT_W   = 32,
    parameter logic [15:0] HOLD_RST = 16'h000A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [TIME_W-1:0] cfg_wdata,
    input  logic              rx_ready,
    input  logic [CNT_W-1:0]  buf_count,
    input  logic              l0_trig,
    input  logic              seq_busy,
    output logic              busy,
    output logic [STAT_W-1:0] status,
    output logic [BCNT_W-1:0] busy_cycles
);
    typedef struct packed {
        logic [TIME_W-1:0]  hold;
        logic [CNT_W-1:0]   limit;
        logic [BURST_W-1:0] size;
        logic [TIME_W-1:0]  leak;
        logic [BCNT_W-1:0]  bcnt;
    } top_st_t;

    top_st_t s_d, s_q;
    logic tick;
    logic hold_act;
    logic burst_act;
    logic buf_full;

    busy_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    busy_holdoff #(.TW(TIME_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick), .l0(l0_trig),
        .hold_time(s_q.hold), .active(hold_act)
    );

    busy_bucket #(.BW(BURST_W), .TW(TIME_W)) u_bucket (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(l0_trig),
        .size(s_q.size), .leak_time(s_q.leak), .burst(burst_act)
    );

    always_comb begin
        buf_full = (s_q.limit != '0) && (buf_count >= s_q.limit);
        status           = '0;
        status[ST_RX]    = !rx_ready;
        status[ST_BUF]   = buf_full;
        status[ST_HOLD]  = hold_act;
        status[ST_SEQ]   = seq_busy;
        status[ST_BURST] = burst_act;
        status[2*CNT_W-1:CNT_W] = buf_count;
        status[CNT_W-1:0]       = s_q.limit;
        busy = |status[ST_RX:ST_BURST];

        s_d = s_q;
        if (cfg_wr) begin
            case (cfg_sel_e'(cfg_addr))
                CFG_HOLD:  s_d.hold  = cfg_wdata;
                CFG_LIMIT: s_d.limit = cfg_wdata[CNT_W-1:0];
                CFG_BURST: s_d.size  = cfg_wdata[BURST_W-1:0];
                default:   s_d.leak  = cfg_wdata;
            endcase
        end
        if (busy) s_d.bcnt = s_q.bcnt + BCNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.hold  <= HOLD_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_cycles = s_q.bcnt;

    assert_rx_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> busy);
    assert_full_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_BUF] |-> busy);
    assert_count_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy_cycles == $past(busy_cycles) + BCNT_W'(1)));
    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(busy_cycles));
endmodule

// File: tb/busy_gen_bench.sv
module busy_gen_bench;
    localparam int TDIV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        rx_ready = 1'b1;
    logic [3:0]  buf_count = 4'd0;
    logic        l0_trig = 1'b0;
    logic        seq_busy = 1'b0;
    logic        busy;
    logic [15:0] status;
    logic [31:0] busy_cycles;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_tcnt, m_rem, m_level, m_lcnt, m_hold, m_limit, m_size, m_leak;
    logic [31:0] m_bcnt;

    always #5 clk = ~clk;

    busy_gen #(.TICK_DIV(TDIV)) u_busy_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_ready(rx_ready), .buf_count(buf_count),
        .l0_trig(l0_trig), .seq_busy(seq_busy), .busy(busy),
        .status(status), .busy_cycles(busy_cycles)
    );

    task automatic model_reset;
        m_tcnt = 0; m_rem = 0; m_level = 0; m_lcnt = 0;
        m_hold = 10; m_limit = 0; m_size = 0; m_leak = 0; m_bcnt = 0;
    endtask

    function automatic logic [15:0] exp_status();
        logic [15:0] s;
        s = 16'd0;
        s[15] = !rx_ready;
        s[14] = (m_limit != 0) && (int'(buf_count) >= m_limit);
        s[13] = (m_rem != 0);
        s[12] = seq_busy;
        s[11] = (m_size != 0) && (m_level >= m_size);
        s[7:4] = buf_count;
        s[3:0] = 4'(m_limit);
        return s;
    endfunction

    task automatic check;
        logic [15:0] es;
        logic eb;
        es = exp_status();
        eb = |es[15:11];
        vectors++;
        if (busy !== eb || status !== es || busy_cycles !== m_bcnt) begin
            miscompares++;
            $display("FAIL %s: busy=%0b status=%h cycles=%0d expected busy=%0b status=%h cycles=%0d",
                     cur_req, busy, status, busy_cycles, eb, es, m_bcnt);
        end
    endtask

    task automatic model_update;
        bit tk, lk;
        int n;
        logic [15:0] es;
        if (!rst_n) begin
            model_reset();
            return;
        end
        es = exp_status();
        if (|es[15:11]) m_bcnt = m_bcnt + 1;
        tk = (m_tcnt == TDIV - 1);
        m_tcnt = tk ? 0 : m_tcnt + 1;
        if (l0_trig) m_rem = m_hold;
        else if (tk && m_rem != 0) m_rem = m_rem - 1;
        lk = 0;
        if (m_leak == 0) m_lcnt = 0;
        else if (tk) begin
            if (m_lcnt + 1 >= m_leak) begin lk = 1; m_lcnt = 0; end
            else m_lcnt = m_lcnt + 1;
        end
        if (m_size == 0) m_level = 0;
        else begin
            n = m_level + (l0_trig ? 1 : 0) - ((lk && m_level > 0) ? 1 : 0);
            if (n > 63) n = 63;
            m_level = n;
        end
        if (cfg_wr) begin
            case (cfg_addr)
                2'd0: m_hold  = int'(cfg_wdata);
                2'd1: m_limit = int'(cfg_wdata[3:0]);
                2'd2: m_size  = int'(cfg_wdata[5:0]);
                default: m_leak = int'(cfg_wdata);
            endcase
        end
    endtask

    task automatic step;
        #1;
        check();
        model_update();
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_l0;
        l0_trig = 1'b1; step(); l0_trig = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] a, input logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; step(); cfg_wr = 1'b0;
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        cur_req = "R1";
        run(3);
        rst_n = 1'b1;
        run(5);

        cur_req = "R2";   // default hold-off of 10 ticks
        pulse_l0();
        run(12 * TDIV);
        cur_req = "R10";
        cfg(2'd0, 16'd3);
        cur_req = "R2";
        pulse_l0();
        run(2 * TDIV);
        pulse_l0();       // retrigger reloads the window
        run(5 * TDIV);
        cfg(2'd0, 16'd0);
        pulse_l0();       // zero hold-off: no window
        run(10);

        cur_req = "R3";
        rx_ready = 1'b0; run(10); rx_ready = 1'b1; run(3);

        cur_req = "R4";
        cfg(2'd0, 16'd2);
        cfg(2'd1, 16'd4);
        buf_count = 4'd5;
        pulse_l0();
        run(4 * TDIV);    // busy outlives the window while full
        buf_count = 4'd3; run(5);
        buf_count = 4'd4; run(5);
        cfg(2'd1, 16'd0);
        buf_count = 4'd15; run(5);
        buf_count = 4'd0;

        cur_req = "R5";
        seq_busy = 1'b1; run(7); seq_busy = 1'b0; run(3);

        cur_req = "R6";
        cfg(2'd0, 16'd0);
        cfg(2'd3, 16'd0);
        cfg(2'd2, 16'd3);
        for (int i = 0; i < 5; i++) begin pulse_l0(); run(2); end
        run(TDIV * 3);
        cfg(2'd2, 16'd0);
        run(3);
        cfg(2'd2, 16'd63);
        for (int i = 0; i < 70; i++) pulse_l0();
        run(5);

        cur_req = "R7";
        cfg(2'd3, 16'd1); // one leak per tick drops the saturated level below 63
        run(3 * TDIV);
        cfg(2'd2, 16'd2);
        cfg(2'd3, 16'd2);
        for (int i = 0; i < 4; i++) pulse_l0();
        run(12 * TDIV);
        for (int i = 0; i < 6 * TDIV; i++) begin
            l0_trig = (i % TDIV == TDIV - 1);
            step();
        end
        l0_trig = 1'b0;
        run(2 * TDIV);

        cur_req = "R8";
        for (int i = 0; i < 6000; i++) begin
            l0_trig  = ($urandom_range(7) == 0);
            if ($urandom_range(15) == 0) seq_busy = ~seq_busy;
            rx_ready = ($urandom_range(31) != 0);
            if ($urandom_range(9) == 0) buf_count = 4'($urandom_range(15));
            cfg_wr = ($urandom_range(49) == 0);
            cfg_addr = 2'($urandom_range(3));
            cfg_wdata = 16'($urandom_range(7));
            if (i % 2000 == 1000) cur_req = "R9";
            else if (i % 2000 == 0) cur_req = "R8";
            step();
        end
        cfg_wr = 1'b0; l0_trig = 1'b0;
        cur_req = "R9";
        run(20);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            miscompares++;
            $display("FAIL %s: watchdog expired actual=hung expected=finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule